// File: doc/BRIEF.md
# Timed ADC Serial-Capture Controller

This block is a serial master for a 12-bit differential converter with a 16-bit serial word. An interval timer starts each acquisition. The block drives an active-low chip select and a serial clock taken from the system clock through a programmable divider. It shifts in one word per frame, most significant bit first, and presents the right-justified 12-bit result with a one-cycle valid strobe.

The block has two modes. In continuous mode each timer tick runs one 16-clock conversion frame. In power-saving mode each tick runs a fixed sequence. First comes a 16-clock dummy frame that wakes the converter, and its data is thrown away. Then comes a 16-clock conversion frame that delivers the result. Last comes an 8-clock truncated burst: chip select rises after it and the converter goes to sleep.

The timer counts whole serial clock periods and advances on the same serial clock phase that starts a frame. Frame starts are therefore always a whole number of serial periods apart. The states are:
- `ST_IDLE`: chip select high.
- `ST_WAKE`: dummy frame.
- `ST_GAP_A`: one serial period with chip select high.
- `ST_CONV`: conversion frame.
- `ST_GAP_B`: one serial period with chip select high.
- `ST_DOZE`: 8-clock burst.

The transitions are:
- `ST_IDLE` to `ST_CONV` or `ST_WAKE` on a tick.
- `ST_WAKE` to `ST_GAP_A` on the last bit.
- `ST_GAP_A` to `ST_CONV` on the next serial period.
- `ST_CONV` to `ST_IDLE` on the last bit in continuous mode, or to `ST_GAP_B` in power-saving mode.
- `ST_GAP_B` to `ST_DOZE` on the next serial period.
- `ST_DOZE` to `ST_IDLE` on the last bit.

Top module: `adc_sample_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cs_n` and `sck` are 1 and `sample_valid` and `overrun` are 0.
- R2: Successive rising edges of `sck` within a frame are 2×(`clk_div`+1) system clocks apart, so a divider value of 3 gives 8 clocks per period.
- R3: With `psave_en`=0, each tick produces one frame with `cs_n` low for exactly 16 rising `sck` edges, after which `cs_n` returns high.
- R4: `sdi` is sampled on each rising `sck` edge, MSB first. `sample` equals bits 11..0 of the 16-bit received word, and bits 15..12 have no effect.
- R5: `sample_valid` is a single-cycle pulse, issued once per conversion frame as `cs_n` rises, with `sample` updated in the same cycle.
- R6: With `psave_en`=1, each tick produces three frames: 16 clocks, then 16 clocks, then 8 clocks. `cs_n` is high for exactly one serial period between consecutive frames and stays high after the last.
- R7: In power-saving mode the first (dummy) frame's data never reaches `sample`. Exactly one `sample_valid` occurs per sequence, carrying the second frame's word.
- R8: Sequence starts (falling `cs_n` of the first frame) are exactly `sample_period`×2×(`clk_div`+1) system clocks apart when no tick is lost.
- R9: A tick that arrives while a sequence is running produces a one-cycle `overrun` pulse and starts nothing. The next sequence starts on the following tick.
- R10: Whenever `cs_n` is high, `sck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| psave_en | input | 1 | 1 selects power-saving sequence, 0 selects continuous mode; latched at each tick |
| clk_div | input | DIV_W | Serial clock divider value |
| sample_period | input | TIMER_W | Sample interval in serial clock periods (0 is treated as 1) |
| sdi | input | 1 | Serial data from converter |
| sck | output | 1 | Serial clock, idle high |
| cs_n | output | 1 | Active-low chip select |
| sample | output | RES_LEN | Captured right-justified result |
| sample_valid | output | 1 | One-cycle strobe for a new `sample` |
| overrun | output | 1 | One-cycle pulse on a tick ignored while busy |

## Verification
The bench builds the block with a 4-bit divider field and an 8-bit interval timer. Intervals of tens of serial periods are then enough to cover full power-saving sequences, continuous frames and deliberately short intervals within a few thousand clocks. It runs divider values 1 and 3, so both the 8-clock period and the general 2×(DIV+1) spacing are observed.

A short interval of 10 periods against a 16-clock frame forces every second tick into the busy window. This exercises the overrun path and shows that sequence spacing doubles. The converter model puts nonzero values in the top four bits and gives dummy frames their own distinct data, so any leak of either one appears as a miscompare.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAKE  = 3'd1,
        ST_GAP_A = 3'd2,
        ST_CONV  = 3'd3,
        ST_GAP_B = 3'd4,
        ST_DOZE  = 3'd5
    } cap_state_e;

endpackage

// File: rtl/sclk_divider.sv
// Free-running serial clock phase generator. The phase toggles every
// DIV+1 system clocks; rise_en marks the system clock edge on which the
// phase goes high.
module sclk_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    output logic             phase,
    output logic             rise_en
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap    = (cnt_q >= div_sel);
    assign rise_en = wrap & ~phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            phase <= 1'b1;
        end else if (wrap) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/interval_timer.sv
// Counts whole serial periods; tick coincides with a rising phase step.
module interval_timer #(
    parameter int TIMER_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [TIMER_W-1:0] period,
    output logic               tick
);
    logic [TIMER_W-1:0] left_q;

    assign tick = step & (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (step) begin
            if (left_q == '0) begin
                left_q <= (period == '0) ? '0 : period - 1'b1;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/shift_in.sv
// Serial-to-parallel register holding the most recent WIDTH bits.
module shift_in #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    generate
        if (WIDTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           word <= '0;
                else if (shift_en) word <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)           word <= '0;
                else if (shift_en) word <= {word[WIDTH-2:0], din};
            end
        end
    endgenerate
endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
    import adc_cap_pkg::*;
#(
    parameter int DIV_W    = 4,
    parameter int TIMER_W  = 12,
    parameter int WORD_LEN = 16,
    parameter int RES_LEN  = 12,
    parameter int DOZE_LEN = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psave_en,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic [TIMER_W-1:0] sample_period,
    input  logic               sdi,
    output logic               sck,
    output logic               cs_n,
    output logic [RES_LEN-1:0] sample,
    output logic               sample_valid,
    output logic               overrun
);
    localparam int CNT_W = $clog2(WORD_LEN + 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_LEN - 1);
    localparam logic [CNT_W-1:0] DOZE_LAST = CNT_W'(DOZE_LEN - 1);

    cap_state_e         state_q, state_d;
    logic [CNT_W-1:0]   bit_q;
    logic               psave_q;
    logic               ph, rise_en, tick;
    logic               in_frame, last_bit;
    logic [RES_LEN-2:0] shreg;

    sclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (clk_div),
        .phase   (ph),
        .rise_en (rise_en)
    );

    interval_timer #(.TIMER_W(TIMER_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .step   (rise_en),
        .period (sample_period),
        .tick   (tick)
    );

    shift_in #(.WIDTH(RES_LEN - 1)) u_shf (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rise_en & in_frame),
        .din      (sdi),
        .word     (shreg)
    );

    always_comb begin
        in_frame = (state_q == ST_WAKE) || (state_q == ST_CONV) || (state_q == ST_DOZE);
        last_bit = rise_en && in_frame &&
                   (bit_q == ((state_q == ST_DOZE) ? DOZE_LAST : WORD_LAST));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick)     state_d = psave_en ? ST_WAKE : ST_CONV;
            ST_WAKE:  if (last_bit) state_d = ST_GAP_A;
            ST_GAP_A: if (rise_en)  state_d = ST_CONV;
            ST_CONV:  if (last_bit) state_d = psave_q ? ST_GAP_B : ST_IDLE;
            ST_GAP_B: if (rise_en)  state_d = ST_DOZE;
            ST_DOZE:  if (last_bit) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            psave_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && tick) psave_q <= psave_en;
            if (state_d != state_q)         bit_q <= '0;
            else if (in_frame && rise_en)   bit_q <= bit_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cs_n = ~in_frame;
        sck  = in_frame ? ph : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample       <= '0;
            sample_valid <= 1'b0;
            overrun      <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            overrun      <= tick && (state_q != ST_IDLE);
            if (state_q == ST_CONV && last_bit) begin
                sample       <= {shreg, sdi};
                sample_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk #(
    parameter int RES_LEN  = 12,
    parameter int WORD_LEN = 16,
    parameter int DOZE_LEN = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               sck,
    input logic               cs_n,
    input logic [RES_LEN-1:0] sample,
    input logic               sample_valid,
    input logic               overrun
);
    logic        sck_d;
    logic [7:0]  rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d    <= 1'b1;
            rise_cnt <= '0;
        end else begin
            sck_d <= sck;
            if (cs_n)              rise_cnt <= '0;
            else if (sck && !sck_d) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    p_sck_idle_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sck);

    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    p_valid_cs_high_r7: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> cs_n);

    p_sample_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> $stable(sample));

    p_frame_len_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !$past(cs_n) && !sck_d) |->
            (sck && (rise_cnt == 8'(WORD_LEN - 1) || rise_cnt == 8'(DOZE_LEN - 1))));

    p_overrun_single_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> !overrun);
endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk #(
    .RES_LEN  (RES_LEN),
    .WORD_LEN (WORD_LEN),
    .DOZE_LEN (DOZE_LEN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sck          (sck),
    .cs_n         (cs_n),
    .sample       (sample),
    .sample_valid (sample_valid),
    .overrun      (overrun)
);

// File: tb/adc_sample_ctrl_tb_top.sv
module adc_sample_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W   = 4;
    localparam int TIMER_W = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               psave_en = 1'b0;
    logic [DIV_W-1:0]   clk_div = '0;
    logic [TIMER_W-1:0] sample_period = 8'd20;
    logic               sdi = 1'b0;
    logic               sck, cs_n, sample_valid, overrun;
    logic [11:0]        sample;

    int n_checks = 0;
    int n_fail   = 0;

    // configuration seen by model and monitor
    bit cfg_ps = 0;
    int cfg_p  = 4;
    int cfg_space = 0;

    logic [11:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sample_ctrl #(.DIV_W(DIV_W), .TIMER_W(TIMER_W)) dut_i (
        .clk (clk), .rst (rst), .psave_en (psave_en), .clk_div (clk_div),
        .sample_period (sample_period), .sdi (sdi), .sck (sck), .cs_n (cs_n),
        .sample (sample), .sample_valid (sample_valid), .overrun (overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
                     req, act, act, exp, exp, $time);
        end
    endtask

    // converter model and scoreboard driver
    int          frame_no = 0;
    logic [15:0] tx_word;
    int          tx_pos;
    always @(negedge cs_n) begin
        int kind;
        kind = cfg_ps ? (frame_no % 3) : 1;
        if (kind == 0)      tx_word = {4'h9, 12'(12'hC3C ^ 12'(frame_no * 37))};
        else                tx_word = {4'(4'hA ^ frame_no), 12'(12'h3A5 + 12'(frame_no * 12'h1F3))};
        if (kind == 1) exp_q.push_back(tx_word[11:0]);   // R7 only conversion frames expected
        tx_pos = 15;
        frame_no++;
    end
    always @(negedge sck) begin
        if (!cs_n && tx_pos >= 0) begin
            sdi = tx_word[tx_pos];
            tx_pos--;
        end
    end

    // monitor
    int  cyc, last_rise, last_start, last_end, rises, mon_idx, starts, valids, ov_cnt;
    bit  have_rise, have_start, p_cs, p_sck, p_val;
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; rises = 0; mon_idx = 0; starts = 0; valids = 0; ov_cnt = 0;
            have_rise = 0; have_start = 0; p_cs = 1; p_sck = 1; p_val = 0;
        end else begin
            int kind, exp_len;
            logic [11:0] e;
            cyc++;
            if (cs_n) chk(sck === 1'b1, "R10 sck idle high", int'(sck), 1);
            if (!p_cs && sck && !p_sck) begin
                if (have_rise) chk(cyc - last_rise == cfg_p, "R2 sck period", cyc - last_rise, cfg_p);
                last_rise = cyc; have_rise = 1; rises++;
            end
            if (p_cs && !cs_n) begin
                rises = 0; have_rise = 0;
                kind = cfg_ps ? (mon_idx % 3) : 0;
                if (kind == 0) begin
                    if (have_start)
                        chk(cyc - last_start == cfg_space, "R8 start spacing", cyc - last_start, cfg_space);
                    last_start = cyc; have_start = 1; starts++;
                end else begin
                    chk(cyc - last_end == cfg_p, "R6 gap between frames", cyc - last_end, cfg_p);
                end
            end
            if (!p_cs && cs_n) begin
                exp_len = (cfg_ps && (mon_idx % 3 == 2)) ? 8 : 16;
                chk(rises == exp_len, cfg_ps ? "R6 frame length" : "R3 frame length", rises, exp_len);
                mon_idx++; last_end = cyc;
            end
            if (sample_valid) begin
                valids++;
                chk(!p_val, "R5 single-cycle valid", int'(p_val), 0);
                chk(cs_n === 1'b1, "R5 valid with cs_n high", int'(cs_n), 1);
                if (exp_q.size() == 0) chk(0, "R7 unexpected result", int'(sample), 0);
                else begin
                    e = exp_q.pop_front();
                    chk(sample == e, "R4 sample value", int'(sample), int'(e));
                end
            end
            if (overrun) ov_cnt++;
            p_cs = cs_n; p_sck = sck; p_val = sample_valid;
        end
    end

    task automatic run_case(input bit ps, input int dv, input int iv, input int nstarts, input int exp_ov);
        int seqp, wt;
        rst = 1'b1;
        psave_en = ps; clk_div = DIV_W'(dv); sample_period = TIMER_W'(iv);
        cfg_ps = ps; cfg_p = 2 * (dv + 1);
        cfg_space = ((exp_ov > 0) ? 2 * iv : iv) * cfg_p;
        exp_q.delete(); frame_no = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(cs_n === 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        chk(sck === 1'b1, "R1 sck in reset", int'(sck), 1);
        chk(sample_valid === 1'b0 && overrun === 1'b0, "R1 strobes in reset",
            int'({sample_valid, overrun}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n === 1'b1 && sample_valid === 1'b0, "R1 after reset", int'({cs_n, sample_valid}), 2);
        seqp = ps ? 44 : 17;
        wt = (nstarts - 1) * cfg_space + (seqp + 2) * cfg_p + 4;
        repeat (wt) @(negedge clk);
        chk(starts == nstarts, ps ? "R6 sequences started" : "R3 frames started", starts, nstarts);
        chk(valids == nstarts, "R7 one result per sequence", valids, nstarts);
        chk(exp_q.size() == 0, "R7 missing results", exp_q.size(), 0);
        chk(ov_cnt == exp_ov, "R9 overrun count", ov_cnt, exp_ov);
    endtask

    initial begin
        fork
            begin
                run_case(1'b0, 3, 24, 4, 0);   // R2 DIV=3 gives 8 clocks; R3 continuous
                run_case(1'b0, 1, 20, 3, 0);   // R3 R8 second divider
                run_case(1'b1, 1, 50, 3, 0);   // R6 R7 power-saving sequence
                run_case(1'b1, 3, 50, 2, 0);   // R6 power-saving, slower clock
                run_case(1'b0, 1, 10, 4, 4);   // R9 tick during busy frame
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule